// File: doc/BRIEF.md
# Parallel Bit Deposit and Extract Unit

This integer execution unit permutes the bits of a source word under a mask supplied at run time. In deposit mode it takes the low-order source bits in turn and places each one at the next mask position holding a one. In extract mode it does the reverse: it collects the source bits found at the mask's one positions and packs them, in ascending order, into the low end of the result. Result bits that no mask bit selects are zero.

An operation starts with a one-cycle `start` pulse, which captures all operands and qualifiers. The unit then walks the mask from its lowest set bit upward and retires one set bit per clock. A narrow operation zero-extends the mask from its lower half, so the upper half of the result is zero. The decode qualifiers are checked on the start cycle. If any of them is not legal, the unit raises a fault strobe instead of running.

The controller has two states. In IDLE it waits for `start`. On a start with legal qualifiers, the transition IDLE->WALK captures the operands. On a start with illegal qualifiers, the transition IDLE->IDLE raises the fault. In WALK, the transition WALK->WALK retires one set mask bit while the captured mask is nonzero. The transition WALK->IDLE fires once the mask is empty: it publishes the result and pulses `done`.

Top module: `bitperm_unit`

## Requirements
- R1: Deposit (prefix byte 8'hF2): source bit k goes to the result position of the k-th lowest set mask bit, with k counting from 0.
- R2: Extract (prefix byte 8'hF3): the source bit at the k-th lowest set mask position goes to result bit k.
- R3: Any result bit that no mask bit selects is zero, so an all-zero mask gives a zero result in both modes.
- R4: With `wide_in` low, only `mask_in[31:0]` is used (zero-extended to 64 bits), and `result[63:32]` is zero. With `wide_in` high, all 64 mask bits are used.
- R5: `done` is a one-cycle strobe. It rises popcount(effective mask)+1 cycles after the clock edge that captured `start`.
- R6: The fault strobe `invalid` pulses for one cycle, one cycle after a start, when any of these holds: `feat_en` is 0, `vex_present` is 0, `vec_len` is nonzero, or `prefix_in` is neither 8'hF2 nor 8'hF3. In that case `done` does not assert and `result` keeps its previous value.
- R7: Operands are captured on the start cycle and may change afterwards. A `start` pulse while an operation is running is ignored.
- R8: Synchronous active-high `rst` clears `done`, `invalid`, `result` and the busy state. An operation interrupted by reset never reports `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; captures operands and qualifiers |
| src_in | input | 64 | Source operand |
| mask_in | input | 64 | Mask operand |
| prefix_in | input | 8 | Mandatory prefix byte: 8'hF2 deposit, 8'hF3 extract |
| wide_in | input | 1 | 1: 64-bit operand size, 0: 32-bit |
| feat_en | input | 1 | Bit-manipulation feature enable |
| vex_present | input | 1 | Vector-extension prefix present |
| vec_len | input | 1 | Vector-length field; must be 0 |
| result | output | 64 | Result; held until the next completion |
| done | output | 1 | One-cycle completion strobe |
| invalid | output | 1 | One-cycle invalid-operation strobe |

## Verification
The hardest case to reach from the ports is a `start` pulse that arrives while a long walk is still in progress. Reaching it needs a mask with many set bits and a second pulse carrying different operands, issued one cycle after the first. The bench uses an all-ones mask for this, so the walk lasts 64 cycles. It then checks that the result and the latency both belong to the first operation. Every operation also changes the operand inputs right after capture, and a reset is applied in the middle of a walk. Together these show that the registered copies, and not the live inputs, drive the result and the completion timing.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_WALK
    } perm_state_t;

    typedef enum logic {
        PERM_DEPOSIT,
        PERM_EXTRACT
    } perm_op_t;

    localparam logic [7:0] PFX_DEPOSIT = 8'hF2;
    localparam logic [7:0] PFX_EXTRACT = 8'hF3;

endpackage

// File: rtl/bitperm_qualify.sv
module bitperm_qualify
    import bitperm_pkg::*;
#(
    parameter int LEN_W = 1
) (
    input  logic [7:0]       prefix,
    input  logic             feat_en,
    input  logic             vex_present,
    input  logic [LEN_W-1:0] vec_len,
    output logic             legal,
    output perm_op_t         op
);

    logic pfx_ok;

    always_comb begin
        pfx_ok = (prefix == PFX_DEPOSIT) || (prefix == PFX_EXTRACT);
        op     = (prefix == PFX_EXTRACT) ? PERM_EXTRACT : PERM_DEPOSIT;
        legal  = feat_en && vex_present && (vec_len == '0) && pfx_ok;
    end

endmodule

// File: rtl/bitperm_lowbit.sv
module bitperm_lowbit #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] vec,
    output logic [WIDTH-1:0] pick,
    output logic             any
);

    always_comb begin
        pick = vec & (~vec + WIDTH'(1));
        any  = (vec != '0);
    end

endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
    import bitperm_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int LEN_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] src_in,
    input  logic [WIDTH-1:0] mask_in,
    input  logic [7:0]       prefix_in,
    input  logic             wide_in,
    input  logic             feat_en,
    input  logic             vex_present,
    input  logic [LEN_W-1:0] vec_len,
    output logic [WIDTH-1:0] result,
    output logic             done,
    output logic             invalid
);

    localparam int HALF = WIDTH / 2;
    localparam int CW   = $clog2(WIDTH + 1);

    perm_state_t      state, state_nx;
    perm_op_t         op_dec, op_q;
    logic             legal;
    logic             wide_q;
    logic [WIDTH-1:0] src_q, mask_q, acc, acc_nx;
    logic [WIDTH-1:0] pick, src_sh, mask_eff;
    logic             any;
    logic [CW-1:0]    idx;
    logic             dep_bit, ext_bit;

    bitperm_qualify #(.LEN_W(LEN_W)) u_qual (
        .prefix      (prefix_in),
        .feat_en     (feat_en),
        .vex_present (vex_present),
        .vec_len     (vec_len),
        .legal       (legal),
        .op          (op_dec)
    );

    bitperm_lowbit #(.WIDTH(WIDTH)) u_low (
        .vec  (mask_q),
        .pick (pick),
        .any  (any)
    );

    always_comb begin
        mask_eff = wide_in ? mask_in : {{HALF{1'b0}}, mask_in[HALF-1:0]};
        src_sh   = src_q >> idx;
        dep_bit  = src_sh[0];
        ext_bit  = |(src_q & pick);
        if (op_q == PERM_DEPOSIT)
            acc_nx = acc | (dep_bit ? pick : '0);
        else
            acc_nx = acc | (WIDTH'(ext_bit) << idx);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start && legal) state_nx = ST_WALK;
            ST_WALK: if (!any)           state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            invalid <= 1'b0;
            result  <= '0;
            src_q   <= '0;
            mask_q  <= '0;
            acc     <= '0;
            idx     <= '0;
            op_q    <= PERM_DEPOSIT;
            wide_q  <= 1'b0;
        end else begin
            done    <= 1'b0;
            invalid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (legal) begin
                            src_q  <= src_in;
                            mask_q <= mask_eff;
                            op_q   <= op_dec;
                            wide_q <= wide_in;
                            acc    <= '0;
                            idx    <= '0;
                        end else begin
                            invalid <= 1'b1;
                        end
                    end
                end
                ST_WALK: begin
                    if (any) begin
                        acc    <= acc_nx;
                        mask_q <= mask_q & (mask_q - WIDTH'(1));
                        idx    <= idx + CW'(1);
                    end else begin
                        result <= acc;
                        done   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    p_done_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(done && invalid));

    p_invalid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        invalid |=> !invalid);

    p_hold_on_fault_r6: assert property (@(posedge clk) disable iff (rst)
        invalid |-> $stable(result));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_walk_shrink_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WALK && any) |=>
            ($countones(mask_q) == $countones($past(mask_q)) - 1));

    p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !wide_q) |-> (result[WIDTH-1:HALF] == '0));

    p_no_capture_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WALK) |=> ($stable(src_q) && $stable(op_q)));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!done && !invalid && state == ST_IDLE));

endmodule

// File: tb/bitperm_unit_test.sv
`timescale 1ns/1ps
module bitperm_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] src_in = '0;
    logic [63:0] mask_in = '0;
    logic [7:0]  prefix_in = 8'hF2;
    logic        wide_in = 1'b1;
    logic        feat_en = 1'b1;
    logic        vex_present = 1'b1;
    logic [0:0]  vec_len = 1'b0;
    logic [63:0] result;
    logic        done;
    logic        invalid;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] last_res = '0;

    always #4 clk = ~clk;

    bitperm_unit uut (
        .clk(clk), .rst(rst), .start(start), .src_in(src_in),
        .mask_in(mask_in), .prefix_in(prefix_in), .wide_in(wide_in),
        .feat_en(feat_en), .vex_present(vex_present), .vec_len(vec_len),
        .result(result), .done(done), .invalid(invalid)
    );

    // {extract, wide, src, mask}
    localparam int NV = 12;
    localparam logic [129:0] VEC [NV] = '{
        {1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
        {1'b1, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0000},
        {1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 1'b1, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000},
        {1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
        {1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_0000_0001},
        {1'b0, 1'b1, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_F0F0},
        {1'b1, 1'b1, 64'hA5A5_A5A5_A5A5_A5A5, 64'h00FF_00FF_00FF_00FF},
        {1'b0, 1'b0, 64'h0000_0000_0000_0003, 64'h0000_0001_0000_0003},
        {1'b1, 1'b1, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001}
    };

    function automatic logic [63:0] ref_op(input logic [63:0] s, m,
                                           input logic ext, w);
        logic [63:0] mm, r;
        int k;
        mm = w ? m : {32'b0, m[31:0]};
        r = '0;
        k = 0;
        for (int i = 0; i < 64; i++) begin
            if (mm[i]) begin
                if (ext) r[k] = s[i];
                else     r[i] = s[k];
                k++;
            end
        end
        return r;
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [63:0] act, exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] s, m, input logic ext, w,
                          input string tag);
        logic [63:0] exp;
        int lat, pc;
        exp = ref_op(s, m, ext, w);
        pc  = $countones(w ? m : {32'b0, m[31:0]});
        @(negedge clk);
        src_in = s; mask_in = m; prefix_in = ext ? 8'hF3 : 8'hF2;
        wide_in = w; feat_en = 1'b1; vex_present = 1'b1; vec_len = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        src_in = ~s; mask_in = ~m;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk(result == exp, tag, result, exp);
        chk(lat == pc + 1, "R5 latency", 64'(lat), 64'(pc + 1));
        last_res = exp;
        @(negedge clk);
        chk(!done, "R5 strobe", 64'(done), 64'd0);
    endtask

    task automatic run_bad(input logic f, vx, input logic vl,
                           input logic [7:0] pfx, input string tag);
        int seen;
        @(negedge clk);
        src_in = 64'h1234_5678_9ABC_DEF0; mask_in = '1; wide_in = 1'b1;
        feat_en = f; vex_present = vx; vec_len = vl; prefix_in = pfx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        feat_en = 1'b1; vex_present = 1'b1; vec_len = 1'b0; prefix_in = 8'hF2;
        chk(invalid == 1'b1, tag, 64'(invalid), 64'd1);
        chk(done == 1'b0, tag, 64'(done), 64'd0);
        chk(result == last_res, tag, result, last_res);
        @(negedge clk);
        chk(invalid == 1'b0, {tag, " pulse"}, 64'(invalid), 64'd0);
        seen = 0;
        repeat (4) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(seen == 0, {tag, " no done"}, 64'(seen), 64'd0);
    endtask

    initial begin
        #(8 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] rs, rm, expa;
        int lat, seen;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0,    "R8 reset done",    64'(done), 64'd0);
        chk(invalid == 1'b0, "R8 reset invalid", 64'(invalid), 64'd0);
        chk(result == '0,    "R8 reset result",  result, 64'd0);

        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][127:64], VEC[v][63:0], VEC[v][129], VEC[v][128],
                   VEC[v][129] ? "R2 extract table" : "R1 deposit table");
        end

        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b0, "R3 zero mask narrow");
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0,
               "R4 upper mask ignored");
        run_op(64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b1,
               "R4 wide upper mask");

        foreach (VEC[i]) begin
            if (i < 4) begin
                int p;
                p = (i == 0) ? 0 : (i == 1) ? 31 : (i == 2) ? 32 : 63;
                run_op(64'h1, 64'h1 << p, 1'b0, 1'b1, "R1 single bit");
                run_op(64'h1 << p, 64'h1 << p, 1'b1, 1'b1, "R2 single bit");
            end
        end

        for (int r = 0; r < 30; r++) begin
            rs = {$urandom, $urandom};
            rm = {$urandom, $urandom};
            run_op(rs, rm, r[0], r[1], r[0] ? "R2 random" : "R1 random");
        end

        // R7: start pulse during a long walk must be ignored
        expa = ref_op(64'h0F0F_1234_5678_9ABC, '1, 1'b0, 1'b1);
        @(negedge clk);
        src_in = 64'h0F0F_1234_5678_9ABC; mask_in = '1; prefix_in = 8'hF2;
        wide_in = 1'b1; start = 1'b1;
        @(negedge clk);
        src_in = 64'hFFFF_0000_FFFF_0000; mask_in = 64'h3; prefix_in = 8'hF3;
        wide_in = 1'b0;
        lat = 0;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk(result == expa, "R7 busy start ignored", result, expa);
        chk(lat == 65, "R7 busy latency", 64'(lat), 64'd65);
        last_res = expa;

        run_bad(1'b0, 1'b1, 1'b0, 8'hF2, "R6 feature off");
        run_bad(1'b1, 1'b0, 1'b0, 8'hF3, "R6 no vex");
        run_bad(1'b1, 1'b1, 1'b1, 8'hF2, "R6 vec_len");
        run_bad(1'b1, 1'b1, 1'b0, 8'h66, "R6 prefix");

        // R8: reset in the middle of a walk
        @(negedge clk);
        src_in = 64'h5555; mask_in = '1; prefix_in = 8'hF2; wide_in = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(done == 1'b0 && invalid == 1'b0, "R8 mid reset",
            64'({done, invalid}), 64'd0);
        chk(result == '0, "R8 mid reset result", result, 64'd0);
        seen = 0;
        repeat (70) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(seen == 0, "R8 aborted op silent", 64'(seen), 64'd0);
        run_op(64'h00FF, 64'hF00F, 1'b1, 1'b1, "R8 after reset R2");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule